// File: doc/BRIEF.md
# Video Memory Address Bus Driver

This block generates the addresses for a tile-based video processor. It holds a 15-bit current address, a 15-bit staging address and a latch that tracks the write sequence. The CPU fills the staging register through an address port that is written twice, high byte first. The second write copies the staging value into the current address. Each access through the data port then steps the current address by 1, or by 32 when the control bit asks for it.

The block drives a 14-bit address bus to external video memory on every cycle, and the bus is never released to high impedance. When rendering is off, or no fetch is in progress, the bus shows the low 14 bits of the current address. A second address-port write therefore appears on the pins straight away, even though no memory access takes place. Repeated writes can raise and lower bit 12 on demand, and a cartridge-side counter can watch that bit.

During rendering, a multiplexer replaces the current address with an address derived for the fetch type: nametable, attribute or pattern. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `vbus_addr_gen`

## Requirements
- R1: Two clock edges after reset is released, the current address, the staging address and the write latch are all zero, and the bus reads 0x0000.
- R2: The bus always carries a known value. It equals current[13:0] whenever render_en is 0 or fetch_kind is 2'b00, whatever the pattern-fetch inputs hold.
- R3: An address write with the latch clear loads staging[13:8] from wr_data[5:0], clears staging[14] and sets the latch. The current address and the bus do not change.
- R4: An address write with the latch set loads staging[7:0] from wr_data, copies the whole staging value into the current address and clears the latch. The new value is on the bus in the cycle after the write edge, with no data access needed.
- R5: A status read clears the latch. If it coincides with an address write, that write acts according to the latch value before the cycle, and the latch is clear afterwards.
- R6: During a data access cycle the bus shows the current address. At the edge the current address grows by 1 when inc_row is 0, or by 32 when inc_row is 1.
- R7: The increment works on all 15 bits. 0x2FFF+1 gives 0x3000, carrying into the fine-Y field current[14:12]. 0x3FE0+32 gives 0x4000, which the bus shows as 0x0000.
- R8: When a second address write and a data access fall in the same cycle, the write sets the current address and that cycle's increment is dropped.
- R9: With render_en=1 and fetch_kind=2'b01 (nametable), the bus is 0x2000 | current[11:0].
- R10: With render_en=1 and fetch_kind=2'b10 (attribute), the bus is 0x23C0 | current[11:10]<<10 | current[9:7]<<3 | current[4:2].
- R11: With render_en=1 and fetch_kind=2'b11 (pattern), the bus is pat_base<<12 | pat_tile<<4 | pat_plane<<3 | current[14:12].
- R12: Fetch cycles leave the current address unchanged. After them, with rendering off, the bus shows the same value as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Address-port write strobe |
| data_acc | input | 1 | Data-port access strobe (read or write) |
| stat_rd | input | 1 | Status-register read strobe, clears the write latch |
| wr_data | input | 8 | CPU write data for the address port |
| inc_row | input | 1 | Increment select: 0 steps by 1, 1 steps by 32 |
| render_en | input | 1 | Rendering enabled |
| fetch_kind | input | 2 | 00 idle, 01 nametable, 10 attribute, 11 pattern |
| pat_base | input | 1 | Pattern table select |
| pat_tile | input | 8 | Fetched tile index |
| pat_plane | input | 1 | Pattern bit-plane select |
| mem_addr | output | 14 | Video memory address bus, always driven |

## Verification
Two functions can fall in the same cycle. A second address write can meet a data access, which pits the load of the current address against the increment. A status read can meet an address write, which pits the latch clear against the write's own latch toggle. The bench provokes each case by raising both strobes on one driven cycle. It judges the outcome on the bus in the following idle cycles: the loaded value must appear with no step added, and the next address write must act as a first write. A reference model of the registers supplies every expected bus value to a scoreboard queue.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'b00,
    FK_NAME = 2'b01,
    FK_ATTR = 2'b10,
    FK_PAT  = 2'b11
  } fetch_e;

  localparam int unsigned FINE_LSB = 12;
endpackage

// File: rtl/vbus_tload.sv
module vbus_tload #(
  parameter int unsigned VW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic          stat_rd,
  input  logic [DW-1:0] wr_data,
  output logic [VW-1:0] t_q,
  output logic          toggle_q,
  output logic          load_v,
  output logic [VW-1:0] load_val
);
  localparam int unsigned HI_W = VW - DW;

  logic [VW-1:0] t_d;
  logic          tog_d;
  logic          t_en;
  logic          tog_en;

  always_comb begin
    t_d   = t_q;
    tog_d = toggle_q;
    if (addr_wr) begin
      if (!toggle_q) begin
        t_d[VW-1]      = 1'b0;
        t_d[VW-2:DW]   = wr_data[HI_W-2:0];
      end else begin
        t_d[DW-1:0]    = wr_data;
      end
      tog_d = ~toggle_q;
    end
    if (stat_rd) tog_d = 1'b0;
  end

  assign t_en     = addr_wr;
  assign tog_en   = addr_wr | stat_rd;
  assign load_v   = addr_wr & toggle_q;
  assign load_val = {t_q[VW-1:DW], wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q      <= '0;
      toggle_q <= 1'b0;
    end else begin
      if (t_en)   t_q      <= t_d;
      if (tog_en) toggle_q <= tog_d;
    end
  end
endmodule

// File: rtl/vbus_vreg.sv
module vbus_vreg #(
  parameter int unsigned VW       = 15,
  parameter int unsigned ROW_STEP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_v,
  input  logic [VW-1:0] load_val,
  input  logic          data_acc,
  input  logic          inc_row,
  output logic [VW-1:0] v_q
);
  localparam logic [VW-1:0] STEP_ROW = VW'(ROW_STEP);
  localparam logic [VW-1:0] STEP_COL = VW'(1);

  logic [VW-1:0] v_d;
  logic          v_en;

  always_comb begin
    if (load_v) v_d = load_val;
    else        v_d = v_q + (inc_row ? STEP_ROW : STEP_COL);
  end

  assign v_en = load_v | data_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_q <= '0;
    else if (v_en) v_q <= v_d;
  end
endmodule

// File: rtl/vbus_fetch_mux.sv
module vbus_fetch_mux
  import vbus_pkg::*;
#(
  parameter int unsigned VW = 15,
  parameter int unsigned AW = 14
) (
  input  logic [VW-1:0] v,
  input  logic          render_en,
  input  logic [1:0]    fetch_kind,
  input  logic          pat_base,
  input  logic [7:0]    pat_tile,
  input  logic          pat_plane,
  output logic [AW-1:0] mem_addr
);
  fetch_e kind;
  logic [AW-1:0] nt_addr;
  logic [AW-1:0] at_addr;
  logic [AW-1:0] pt_addr;

  assign kind    = fetch_e'(fetch_kind);
  assign nt_addr = {2'b10, v[11:0]};
  assign at_addr = {2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]};
  assign pt_addr = {1'b0, pat_base, pat_tile, pat_plane, v[VW-1:FINE_LSB]};

  always_comb begin
    mem_addr = v[AW-1:0];
    if (render_en) begin
      unique case (kind)
        FK_NAME: mem_addr = nt_addr;
        FK_ATTR: mem_addr = at_addr;
        FK_PAT:  mem_addr = pt_addr;
        default: mem_addr = v[AW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/vbus_addr_gen.sv
module vbus_addr_gen #(
  parameter int unsigned VW       = 15,
  parameter int unsigned AW       = 14,
  parameter int unsigned DW       = 8,
  parameter int unsigned ROW_STEP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic          data_acc,
  input  logic          stat_rd,
  input  logic [DW-1:0] wr_data,
  input  logic          inc_row,
  input  logic          render_en,
  input  logic [1:0]    fetch_kind,
  input  logic          pat_base,
  input  logic [7:0]    pat_tile,
  input  logic          pat_plane,
  output logic [AW-1:0] mem_addr
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [VW-1:0] t_cur;
  logic [VW-1:0] v_cur;
  logic [VW-1:0] load_val;
  logic          toggle;
  logic          load_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  vbus_tload #(.VW(VW), .DW(DW)) u_tload (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_wr  (addr_wr),
    .stat_rd  (stat_rd),
    .wr_data  (wr_data),
    .t_q      (t_cur),
    .toggle_q (toggle),
    .load_v   (load_v),
    .load_val (load_val)
  );

  vbus_vreg #(.VW(VW), .ROW_STEP(ROW_STEP)) u_vreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_v   (load_v),
    .load_val (load_val),
    .data_acc (data_acc),
    .inc_row  (inc_row),
    .v_q      (v_cur)
  );

  vbus_fetch_mux #(.VW(VW), .AW(AW)) u_mux (
    .v          (v_cur),
    .render_en  (render_en),
    .fetch_kind (fetch_kind),
    .pat_base   (pat_base),
    .pat_tile   (pat_tile),
    .pat_plane  (pat_plane),
    .mem_addr   (mem_addr)
  );
endmodule

// File: rtl/vbus_addr_gen_chk.sv
module vbus_addr_gen_chk #(
  parameter int unsigned VW = 15,
  parameter int unsigned AW = 14,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_wr,
  input logic          data_acc,
  input logic          stat_rd,
  input logic [DW-1:0] wr_data,
  input logic          inc_row,
  input logic          render_en,
  input logic [1:0]    fetch_kind,
  input logic [AW-1:0] mem_addr,
  input logic [VW-1:0] v_cur,
  input logic [VW-1:0] t_cur,
  input logic          toggle
);
  // R2
  bus_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(mem_addr));

  // R2
  idle_shows_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_en || fetch_kind == 2'b00) |-> mem_addr == v_cur[AW-1:0]);

  // R3
  first_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !toggle && !data_acc) |=> ($stable(v_cur) && toggle));

  // R4
  second_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && toggle) |=> v_cur == $past({t_cur[VW-1:DW], wr_data}));

  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !toggle);

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !(addr_wr && toggle)) |=>
      v_cur == $past(v_cur) + ($past(inc_row) ? VW'(32) : VW'(1)));

  // R11
  pattern_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && fetch_kind == 2'b11) |-> mem_addr[2:0] == v_cur[VW-1:VW-3]);
endmodule

bind vbus_addr_gen vbus_addr_gen_chk #(.VW(VW), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .addr_wr    (addr_wr),
  .data_acc   (data_acc),
  .stat_rd    (stat_rd),
  .wr_data    (wr_data),
  .inc_row    (inc_row),
  .render_en  (render_en),
  .fetch_kind (fetch_kind),
  .mem_addr   (mem_addr),
  .v_cur      (v_cur),
  .t_cur      (t_cur),
  .toggle     (toggle)
);

// File: tb/vbus_addr_gen_tb.sv
`timescale 1ns/1ps
module vbus_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_wr, data_acc, stat_rd, inc_row, render_en;
  logic       pat_base, pat_plane;
  logic [7:0] wr_data, pat_tile;
  logic [1:0] fetch_kind;
  logic [13:0] mem_addr;

  always #2.5 clk = ~clk;

  vbus_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_acc(data_acc),
    .stat_rd(stat_rd), .wr_data(wr_data), .inc_row(inc_row),
    .render_en(render_en), .fetch_kind(fetch_kind), .pat_base(pat_base),
    .pat_tile(pat_tile), .pat_plane(pat_plane), .mem_addr(mem_addr)
  );

  typedef struct {
    logic [13:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  logic [14:0] mv = '0;
  logic [14:0] mt = '0;
  logic        mtog = 1'b0;

  // Monitor: compares the bus against queued expectations mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (mem_addr !== it.val) begin
          errors++;
          $display("FAIL %s: mem_addr=%h expected=%h", it.tag, mem_addr, it.val);
        end
      end
    end
  end

  // Driver: drives one cycle, pushes the expected bus, advances the model.
  task automatic step(input logic aw, input logic da, input logic sr,
                      input logic [7:0] d, input logic i32, input logic ren,
                      input logic [1:0] k, input logic b, input logic [7:0] tl,
                      input logic pl, input string tag, input bit chk);
    logic [13:0] e;
    logic [14:0] nv;
    logic [14:0] nt;
    logic        ntog;
    @(negedge clk);
    addr_wr = aw; data_acc = da; stat_rd = sr; wr_data = d; inc_row = i32;
    render_en = ren; fetch_kind = k; pat_base = b; pat_tile = tl; pat_plane = pl;
    e = mv[13:0];
    if (ren) begin
      case (k)
        2'b01: e = 14'h2000 | 14'(mv[11:0]);
        2'b10: e = 14'h23C0 | (14'(mv[11:10]) << 10) | (14'(mv[9:7]) << 3) | 14'(mv[4:2]);
        2'b11: e = (14'(b) << 12) | (14'(tl) << 4) | (14'(pl) << 3) | 14'(mv[14:12]);
        default: e = mv[13:0];
      endcase
    end
    if (chk) q.push_back('{e, tag});
    nv = mv; nt = mt; ntog = mtog;
    if (aw && mtog)  nv = {mt[14:8], d};
    else if (da)     nv = mv + (i32 ? 15'd32 : 15'd1);
    if (aw && !mtog) begin nt[14] = 1'b0; nt[13:8] = d[5:0]; end
    if (aw && mtog)  nt[7:0] = d;
    if (aw) ntog = ~mtog;
    if (sr) ntog = 1'b0;
    mv = nv; mt = nt; mtog = ntog;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 8'h00, 0, 0, 2'b00, 0, 8'h00, 0, tag, 1);
  endtask

  task automatic wr_addr(input logic [7:0] d, input string tag);
    step(1, 0, 0, d, 0, 0, 2'b00, 0, 8'h00, 0, tag, 1);
  endtask

  task automatic fetch(input logic [1:0] k, input string tag);
    step(0, 0, 0, 8'h00, 0, 1, k, 1, 8'hA5, 1, tag, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    addr_wr = 0; data_acc = 0; stat_rd = 0; wr_data = 0; inc_row = 0;
    render_en = 0; fetch_kind = 0; pat_base = 0; pat_tile = 0; pat_plane = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    idle("R1 reset state");
    // R3 first write leaves v alone
    wr_addr(8'h3F, "R3 first write cycle");
    idle("R3 v unchanged after first write");
    // R4 second write shows at once
    wr_addr(8'h12, "R4 second write cycle");
    idle("R4 new v on bus");
    // R4 toggling bit 12 by repeated writes
    wr_addr(8'h00, "R4 a12 low first");
    wr_addr(8'h00, "R4 a12 low second");
    idle("R4 a12 low");
    wr_addr(8'h10, "R4 a12 high first");
    wr_addr(8'h00, "R4 a12 high second");
    idle("R4 a12 high");
    // R5 status read resets the sequence
    wr_addr(8'h21, "R5 first write");
    step(0, 0, 1, 8'h00, 0, 0, 2'b00, 0, 8'h00, 0, "R5 status read", 1);
    wr_addr(8'h05, "R5 restart first");
    idle("R5 v held");
    wr_addr(8'h66, "R5 restart second");
    idle("R5 loaded");
    // R5 status read with second write in the same cycle
    wr_addr(8'h07, "R5 coincide first");
    step(1, 0, 1, 8'h23, 0, 0, 2'b00, 0, 8'h00, 0, "R5 coincide second", 1);
    idle("R5 coincide loaded");
    wr_addr(8'h01, "R5 next is first");
    idle("R5 next first held");
    wr_addr(8'h80, "R5 next second");
    idle("R5 next loaded");
    // R6 and R7 increments
    wr_addr(8'h2F, "R7 load hi");
    wr_addr(8'hFF, "R7 load lo");
    step(0, 1, 0, 8'h00, 0, 0, 2'b00, 0, 8'h00, 0, "R6 bus shows v during access", 1);
    idle("R7 fine-Y carry 0x3000");
    step(0, 1, 0, 8'h00, 1, 0, 2'b00, 0, 8'h00, 0, "R6 row step access", 1);
    idle("R6 plus 32");
    step(0, 1, 0, 8'h00, 0, 0, 2'b00, 0, 8'h00, 0, "R6 col step access", 1);
    idle("R6 plus 1");
    wr_addr(8'h3F, "R7 load hi 3F");
    wr_addr(8'hE0, "R7 load lo E0");
    step(0, 1, 0, 8'h00, 1, 0, 2'b00, 0, 8'h00, 0, "R7 access at 0x3FE0", 1);
    idle("R7 bit14 carry bus 0x0000");
    fetch(2'b11, "R11 pattern fine-Y from bit14");
    // R8 collision of second write and data access
    wr_addr(8'h01, "R8 first");
    step(1, 1, 0, 8'h23, 1, 0, 2'b00, 0, 8'h00, 0, "R8 write plus access", 1);
    idle("R8 no increment");
    // R9 R10 R11 fetches
    wr_addr(8'h1A, "R9 load hi");
    wr_addr(8'hD7, "R9 load lo");
    fetch(2'b01, "R9 nametable");
    fetch(2'b10, "R10 attribute");
    fetch(2'b11, "R11 pattern");
    fetch(2'b00, "R2 render idle kind shows v");
    step(0, 0, 0, 8'h00, 0, 0, 2'b11, 1, 8'hFF, 1, "R2 render off ignores fetch inputs", 1);
    idle("R12 v unchanged after fetches");
    idle("R2 settle");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: expected=finish actual=timeout");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule